// File: doc/BRIEF.md
# TDM Slot-Masked Serial Transmitter

This block is the transmit side of a synchronous serial port working in time-division multiplexed (network) mode. One clock cycle carries one bit. A frame sync pulse starts slot 0. Each slot is `WORD_W` bits long, and a frame holds a programmable number of slots, up to `SLOT_N`. The host loads a transmit word or writes a blank-slot strobe, and the block sends that word MSB first in the next enabled slot. If the host wrote a blank instead, that slot is left at high impedance.

A 32-bit slot mask decides which slots take part in transmission. The host writes the mask as two 16-bit halves. A slot whose mask bit is clear keeps the data pin tri-stated. A masked slot does not consume the pending word, does not set the empty flag and cannot cause an underrun. As a result, the host is interrupted only by activity in enabled slots.

The block also produces a transmit-empty flag, an underrun flag and an interrupt request. The interrupt request carries a vector-select bit that chooses between the normal vector and the underrun vector.

Top module: `tdm_slot_tx`

## Requirements
- R1: After reset, `tx_empty_o`=1, `underrun_o`=0, `sd_oe_o`=0 and `slot_mask_o`=0. The shift register holds zero in driven mode, so an enabled slot that underruns before any load sends zeros.
- R2: A write with `mask_lo_wr_i` sets mask bits 15:0 from `mask_half_i`, and a write with `mask_hi_wr_i` sets bits 31:16. The new value appears on `slot_mask_o` one cycle later. Bit N enables slot N.
- R3: At the start of an enabled slot with a word pending (`tx_empty_o`=0), the word moves into the shift register and `tx_empty_o` sets. During that slot the word drives `sd_o` MSB first, one bit per cycle, with `sd_oe_o`=1.
- R4: In a slot whose mask bit is clear, `sd_oe_o` stays 0 for the whole slot, and `tx_empty_o` and `underrun_o` do not change.
- R5: A pending word is not consumed by masked slots. It is sent in the next enabled slot.
- R6: A write with `blank_wr_i` is handled like a data write, except that the enabled slot which consumes it keeps `sd_oe_o`=0.
- R7: When an enabled slot starts while `tx_empty_o`=1, `underrun_o` sets and the previous slot contents (data or blank) are sent again.
- R8: A write with `tx_wr_i` or `blank_wr_i` clears both `tx_empty_o` and `underrun_o`.
- R9: `irq_o` is high exactly when `tie_i`=1 and `tx_empty_o`=1. `irq_vec_o` equals `underrun_o`, where 1 selects the underrun vector.
- R10: `fsync_i` starts slot 0. A frame lasts `frame_len_i`+1 slots, after which `sd_oe_o` stays 0 until the next frame sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | Frame sync; the following cycle is bit 0 of slot 0 |
| frame_len_i | input | 5 | Number of slots per frame minus one |
| tx_wr_i | input | 1 | Transmit data register write strobe |
| tx_data_i | input | 16 | Transmit data word |
| blank_wr_i | input | 1 | Blank-slot register write strobe |
| mask_lo_wr_i | input | 1 | Write strobe for mask bits 15:0 |
| mask_hi_wr_i | input | 1 | Write strobe for mask bits 31:16 |
| mask_half_i | input | 16 | Mask half write data |
| tie_i | input | 1 | Transmit interrupt enable |
| slot_mask_o | output | 32 | Current slot mask (readback) |
| sd_o | output | 1 | Serial data |
| sd_oe_o | output | 1 | Serial data output enable |
| tx_empty_o | output | 1 | Transmit-empty flag |
| underrun_o | output | 1 | Underrun flag |
| irq_o | output | 1 | Transmit interrupt request |
| irq_vec_o | output | 1 | Vector select: 1 = underrun |

## Verification
Random frames are run with random masks, random frame lengths and a random host action in each slot. The action is a data write, a blank write or no write. Together these separate correct data delivery from three failure modes: loading during masked slots, underruns raised in masked slots, and resending the wrong contents. Directed frames cover the state right after reset, a fully enabled mask, a frame length of one slot and a frame of 32 slots. Idle checks after each frame confirm that the frame ends after exactly the programmed number of slots.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned SLOT_N = 32;
endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned SLOT_N = 32,
  localparam int unsigned BIT_W  = $clog2(WORD_W),
  localparam int unsigned SLOT_W = $clog2(SLOT_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fsync_i,
  input  logic [SLOT_W-1:0] frame_len_i,
  output logic              slot_start_o,
  output logic [SLOT_W-1:0] next_slot_o,
  output logic              active_o
);
  logic [BIT_W-1:0]  bit_q;
  logic [SLOT_W-1:0] slot_q;
  logic              run_q;
  logic              last_bit, frame_end;

  assign last_bit     = run_q && (bit_q == BIT_W'(WORD_W - 1));
  assign slot_start_o = fsync_i || (last_bit && (slot_q != frame_len_i));
  assign frame_end    = last_bit && (slot_q == frame_len_i) && !fsync_i;
  assign next_slot_o  = fsync_i ? '0 : slot_q + SLOT_W'(1);
  assign active_o     = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= '0;
      slot_q <= '0;
      run_q  <= 1'b0;
    end else if (slot_start_o) begin
      bit_q  <= '0;
      slot_q <= next_slot_o;
      run_q  <= 1'b1;
    end else if (frame_end) begin
      bit_q  <= '0;
      run_q  <= 1'b0;
    end else if (run_q) begin
      bit_q  <= bit_q + BIT_W'(1);
    end
  end
endmodule

// File: rtl/tdm_slot_mask.sv
module tdm_slot_mask #(
  parameter int unsigned SLOT_N = 32,
  localparam int unsigned HALF_W = SLOT_N / 2,
  localparam int unsigned SLOT_W = $clog2(SLOT_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lo_wr_i,
  input  logic              hi_wr_i,
  input  logic [HALF_W-1:0] half_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [SLOT_N-1:0] mask_o,
  output logic              slot_en_o
);
  logic [SLOT_N-1:0] mask_q;

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mask_q[h*HALF_W +: HALF_W] <= '0;
      else if ((h == 0) ? lo_wr_i : hi_wr_i) mask_q[h*HALF_W +: HALF_W] <= half_i;
    end
  end

  assign mask_o    = mask_q;
  assign slot_en_o = mask_q[slot_i];
endmodule

// File: rtl/tdm_tx_datapath.sv
module tdm_tx_datapath #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slot_start_i,
  input  logic              slot_en_i,
  input  logic              active_i,
  input  logic              tx_wr_i,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              blank_wr_i,
  output logic              sd_o,
  output logic              sd_oe_o,
  output logic              tx_empty_o,
  output logic              underrun_o
);
  logic [WORD_W-1:0] hold_q, shift_q;
  logic              blank_q, drive_q, en_q, empty_q, ur_q;
  logic              host_wr, load, ur_evt;

  assign host_wr = tx_wr_i || blank_wr_i;
  assign load    = slot_start_i && slot_en_i && !empty_q;
  assign ur_evt  = slot_start_i && slot_en_i && empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      blank_q <= 1'b0;
      shift_q <= '0;
      drive_q <= 1'b1;
      en_q    <= 1'b0;
      empty_q <= 1'b1;
      ur_q    <= 1'b0;
    end else begin
      if (tx_wr_i) begin
        hold_q  <= tx_data_i;
        blank_q <= 1'b0;
      end else if (blank_wr_i) begin
        blank_q <= 1'b1;
      end
      // rotate so an underrun slot replays the same word
      if (load) begin
        shift_q <= hold_q;
        drive_q <= !blank_q;
      end else if (active_i) begin
        shift_q <= {shift_q[WORD_W-2:0], shift_q[WORD_W-1]};
      end
      if (slot_start_i) en_q <= slot_en_i;
      if (host_wr)   empty_q <= 1'b0;
      else if (load) empty_q <= 1'b1;
      if (host_wr)     ur_q <= 1'b0;
      else if (ur_evt) ur_q <= 1'b1;
    end
  end

  assign sd_o       = shift_q[WORD_W-1];
  assign sd_oe_o    = active_i && en_q && drive_q;
  assign tx_empty_o = empty_q;
  assign underrun_o = ur_q;
endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx
  import tdm_tx_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fsync_i,
  input  logic [4:0]    frame_len_i,
  input  logic          tx_wr_i,
  input  logic [15:0]   tx_data_i,
  input  logic          blank_wr_i,
  input  logic          mask_lo_wr_i,
  input  logic          mask_hi_wr_i,
  input  logic [15:0]   mask_half_i,
  input  logic          tie_i,
  output logic [31:0]   slot_mask_o,
  output logic          sd_o,
  output logic          sd_oe_o,
  output logic          tx_empty_o,
  output logic          underrun_o,
  output logic          irq_o,
  output logic          irq_vec_o
);
  localparam int unsigned SLOT_W = $clog2(SLOT_N);

  logic              slot_start, active, slot_en_nx;
  logic [SLOT_W-1:0] next_slot;

  tdm_slot_timer #(.WORD_W(WORD_W), .SLOT_N(SLOT_N)) i_timer (
    .clk_i, .rst_ni, .fsync_i, .frame_len_i,
    .slot_start_o(slot_start), .next_slot_o(next_slot), .active_o(active)
  );

  tdm_slot_mask #(.SLOT_N(SLOT_N)) i_mask (
    .clk_i, .rst_ni, .lo_wr_i(mask_lo_wr_i), .hi_wr_i(mask_hi_wr_i),
    .half_i(mask_half_i), .slot_i(next_slot), .mask_o(slot_mask_o),
    .slot_en_o(slot_en_nx)
  );

  tdm_tx_datapath #(.WORD_W(WORD_W)) i_dp (
    .clk_i, .rst_ni, .slot_start_i(slot_start), .slot_en_i(slot_en_nx),
    .active_i(active), .tx_wr_i, .tx_data_i, .blank_wr_i,
    .sd_o, .sd_oe_o, .tx_empty_o, .underrun_o
  );

  assign irq_o     = tie_i && tx_empty_o;
  assign irq_vec_o = underrun_o;
endmodule

// File: rtl/tdm_slot_tx_chk.sv
module tdm_slot_tx_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tx_wr_i,
  input logic        blank_wr_i,
  input logic        mask_lo_wr_i,
  input logic [15:0] mask_half_i,
  input logic [31:0] slot_mask_o,
  input logic        tx_empty_o,
  input logic        underrun_o,
  input logic        slot_start,
  input logic        slot_en_nx
);
  logic any_wr;
  assign any_wr = tx_wr_i || blank_wr_i;

  p_mask_lo_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_lo_wr_i |=> slot_mask_o[15:0] == $past(mask_half_i));

  p_load_sets_empty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_start && slot_en_nx && !tx_empty_o && !any_wr) |=> tx_empty_o);

  p_masked_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_start && !slot_en_nx && !any_wr) |=> $stable(tx_empty_o) && $stable(underrun_o));

  p_underrun_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underrun_o) |-> $past(tx_empty_o) && $past(slot_en_nx));

  p_write_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_wr |=> !tx_empty_o && !underrun_o);
endmodule

bind tdm_slot_tx tdm_slot_tx_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_wr_i(tx_wr_i), .blank_wr_i(blank_wr_i),
  .mask_lo_wr_i(mask_lo_wr_i), .mask_half_i(mask_half_i),
  .slot_mask_o(slot_mask_o), .tx_empty_o(tx_empty_o), .underrun_o(underrun_o),
  .slot_start(slot_start), .slot_en_nx(slot_en_nx)
);

// File: tb/test_tdm_slot_tx.sv
module test_tdm_slot_tx;
  localparam int W = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic fsync_i = 0, tx_wr_i = 0, blank_wr_i = 0, mask_lo_wr_i = 0, mask_hi_wr_i = 0, tie_i = 0;
  logic [4:0]  frame_len_i = '0;
  logic [15:0] tx_data_i = '0, mask_half_i = '0;
  logic [31:0] slot_mask_o;
  logic sd_o, sd_oe_o, tx_empty_o, underrun_o, irq_o, irq_vec_o;

  int n_vec = 0, n_err = 0;
  bit done = 0;

  logic        m_tde, m_ur, m_pb, m_cd;
  logic [15:0] m_pw, m_cw;
  logic [31:0] m_mask;

  always #2.5 clk_i = ~clk_i;

  tdm_slot_tx i_tdm_slot_tx (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_irq(input logic tie, input logic tde);
    return tie & tde;
  endfunction

  task automatic set_mask(input logic [31:0] m);
    @(negedge clk_i);
    mask_lo_wr_i = 1; mask_half_i = m[15:0];
    @(negedge clk_i);
    mask_lo_wr_i = 0; mask_hi_wr_i = 1; mask_half_i = m[31:16];
    @(negedge clk_i);
    mask_hi_wr_i = 0;
    m_mask = m;
    chk("R2 mask readback", slot_mask_o, m);
  endtask

  task automatic idle_write(input bit blank, input logic [15:0] d);
    @(negedge clk_i);
    if (blank) blank_wr_i = 1; else begin tx_wr_i = 1; tx_data_i = d; end
    @(negedge clk_i);
    tx_wr_i = 0; blank_wr_i = 0;
    m_tde = 0; m_ur = 0; m_pb = blank;
    if (!blank) m_pw = d;
    chk("R8 empty cleared", {31'd0, tx_empty_o}, 32'd0);
  endtask

  // act_mode: 0 random, 1 always data, 2 never
  task automatic run_frame(input int len, input int act_mode);
    logic en, oe;
    int   act;
    @(negedge clk_i);
    frame_len_i = 5'(len - 1);
    fsync_i = 1;
    for (int s = 0; s < len; s++) begin
      @(posedge clk_i);
      en = m_mask[s];
      if (en) begin
        if (m_tde) m_ur = 1;
        else begin m_cw = m_pw; m_cd = !m_pb; m_tde = 1; end
      end
      oe = en & m_cd;
      act = (act_mode == 1) ? 1 : (act_mode == 2) ? 0 : int'($urandom % 4);
      for (int b = 0; b < W; b++) begin
        @(negedge clk_i);
        fsync_i = 0; tx_wr_i = 0; blank_wr_i = 0;
        chk(en ? (m_cd ? "R3 oe" : "R6 blank oe") : "R4 masked oe", {31'd0, sd_oe_o}, {31'd0, oe});
        if (oe) chk("R3 data bit", {31'd0, sd_o}, {31'd0, m_cw[W-1-b]});
        if (b == 1 || b == W/2 + 1) begin
          chk(en ? "R5 empty" : "R4 empty kept", {31'd0, tx_empty_o}, {31'd0, m_tde});
          chk(en ? "R7 underrun" : "R4 underrun kept", {31'd0, underrun_o}, {31'd0, m_ur});
          chk("R9 irq", {30'd0, irq_vec_o, irq_o}, {30'd0, m_ur, exp_irq(tie_i, m_tde)});
        end
        if (b == W/2 && act != 0) begin
          if (act == 3) begin blank_wr_i = 1; m_pb = 1; end
          else begin
            tx_wr_i = 1; tx_data_i = 16'($urandom);
            m_pw = tx_data_i; m_pb = 0;
          end
          m_tde = 0; m_ur = 0;
        end
        if (b < W - 1) @(posedge clk_i);
      end
    end
    @(posedge clk_i);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      tx_wr_i = 0; blank_wr_i = 0;
      chk("R10 idle after frame", {31'd0, sd_oe_o}, 32'd0);
    end
  endtask

  initial begin
    #(5 * 190000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    m_tde = 1; m_ur = 0; m_pb = 0; m_cd = 1; m_pw = '0; m_cw = '0; m_mask = '0;
    #12 rst_ni = 1;
    @(negedge clk_i);
    chk("R1 reset empty", {31'd0, tx_empty_o}, 32'd1);
    chk("R1 reset underrun", {31'd0, underrun_o}, 32'd0);
    chk("R1 reset oe", {31'd0, sd_oe_o}, 32'd0);
    chk("R1 reset mask", slot_mask_o, 32'd0);
    // underrun straight after reset sends zeros
    tie_i = 1;
    set_mask(32'hFFFF_FFFF);
    run_frame(2, 2);
    idle_write(0, 16'hA5C3);
    run_frame(1, 0);
    // frame of 32 slots, fully enabled, data every slot
    run_frame(32, 1);
    // alternate masked slots with a blank pending
    set_mask(32'h5555_AAAA);
    idle_write(1, 16'h0);
    run_frame(8, 2);
    for (int f = 0; f < 40; f++) begin
      set_mask($urandom);
      tie_i = 1'($urandom);
      if ($urandom % 2 == 1) idle_write(1'($urandom), 16'($urandom));
      run_frame(1 + int'($urandom % 32), 0);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule